// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control for a 10-bit successive-approximation analog-to-digital converter. Software-style control arrives as an enable bit, a run bit, an analog channel number and a 3-bit speed code. The analog side feeds back one comparator bit that says whether the held input is at or above the current DAC tap. The block drives the channel mux, the sample/hold switch and the trial code for the DAC tap. It also drives two result registers and a single-cycle end-of-conversion pulse.

After enable has been high long enough for the analog front end to settle, raising run starts a sampling phase. Ten bit trials follow, MSB first. Each finished code is written to a left-justified 16-bit register and to an 8-bit register holding the top eight bits. The sequence then starts again on its own for as long as run stays high. Dropping run or enable abandons the conversion in progress.

Top module: `sar_adc_seq`

## Requirements
- R1: During and after reset, result_o, result_hi_o, dac_code_o, sample_o and eoc_o are all 0.
- R2: Sampling cannot begin until en_i has been high for SETTLE_CYC consecutive clocks (default 250, one microsecond at 250 MHz). With en_i and run_i raised together, sample_o first goes high after SETTLE_CYC+1 clock edges.
- R3: The sampling phase asserts sample_o (1 = sample, 0 = hold) for exactly SMP_BASE*(ctime+1) clocks. sample_o stays low for the rest of the conversion.
- R4: The first trial code after sampling is 10'h200, which places the tap at half of the reference.
- R5: In each trial, the bit under test stays 1 when cmp_i is 1 (input at or above the tap) and is cleared when cmp_i is 0. The next lower bit is set for the following trial. With an ideal comparator, the final code equals the input code.
- R6: Each bit trial lasts BIT_BASE*(ctime+1) clocks. When warmed up and idle, eoc_o rises 1+SMP_BASE*(ctime+1)+10*BIT_BASE*(ctime+1) edges after run_i is raised.
- R7: On completion, result_o = {code, 6'b0} (code in bits 15:6) and result_hi_o = code[9:2].
- R8: eoc_o is high for exactly one clock, in the same cycle the result registers first show the new code.
- R9: While run_i stays high, conversions repeat back to back, one every SMP_BASE*(ctime+1)+10*BIT_BASE*(ctime+1) clocks.
- R10: Clearing run_i mid-conversion returns the block to idle on the next edge. No eoc_o pulse follows, and both result registers keep their previous values.
- R11: ch_sel_o is captured from ch_i only when a sampling phase begins. A change to ch_i during a conversion shows up at the next sampling phase.
- R12: Dropping en_i clears the settling count, so a later start needs the full SETTLE_CYC wait again. A restart while en_i stays high needs no new settling wait.
- R13: ctime_i is captured at the start of each sampling phase and sets the phase lengths of that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; starts the settling count |
| run_i | input | 1 | Run; converts continuously while high |
| ch_i | input | CH_W | Requested analog channel |
| ctime_i | input | CT_W | Conversion speed code |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the tap |
| ch_sel_o | output | CH_W | Channel mux select |
| sample_o | output | 1 | 1 = sample, 0 = hold |
| dac_code_o | output | RES | Trial code to the DAC tap selector |
| result_o | output | RES_W | Left-justified 16-bit result |
| result_hi_o | output | HI_W | Upper eight result bits |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
Every timed result is counted in clock edges from the negative edge where the stimulus was driven. The first sample_o rise is due SETTLE_CYC+1 edges after enable and run rise together. eoc_o is due 1+SMP+10*BIT edges after run rises on a warmed-up block, and every SMP+10*BIT edges after that during continuous runs. The bench counts edges one by one and reads outputs only at negative edges, so each count matches its formula exactly. The trial code is checked on the first negative edge after sample_o falls. The result registers and the channel change are checked on the negative edge where eoc_o is seen high.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONV
  } sar_state_e;
endpackage

// File: rtl/sar_warmup.sv
module sar_warmup #(
  parameter int SETTLE_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic warm_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign warm_o = (cnt_q == CW'(SETTLE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (!warm_o)       cnt_q <= cnt_q + CW'(1);
  end

  AST_WARM_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !warm_o) else $error("warm without enable"); // R12
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int RES = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic           cmp_i,
  output logic [RES-1:0] trial_o,
  output logic [RES-1:0] final_o,
  output logic           last_o
);
  localparam int IW = $clog2(RES);

  logic [RES-1:0] code_q, nxt;
  logic [IW-1:0]  idx_q;

  assign trial_o = code_q;
  assign last_o  = (idx_q == '0);

  always_comb begin
    final_o        = code_q;
    final_o[idx_q] = cmp_i;   // keep bit when input >= tap
    nxt            = final_o;
    if (idx_q != '0) nxt[idx_q - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      code_q <= {1'b1, {(RES-1){1'b0}}};
      idx_q  <= IW'(RES-1);
    end else if (step_i) begin
      code_q <= nxt;
      if (idx_q != '0) idx_q <= idx_q - IW'(1);
    end
  end

  AST_FIRST_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> trial_o == {1'b1, {(RES-1){1'b0}}}) else $error("bad first trial"); // R4
  AST_HIGH_BITS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !last_o && !load_i) |=> trial_o[RES-1] == $past(final_o[RES-1])) else $error("msb lost"); // R5
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int RES        = 10,
  parameter int RES_W      = 16,
  parameter int HI_W       = 8,
  parameter int CH_W       = 3,
  parameter int CT_W       = 3,
  parameter int SETTLE_CYC = 250,
  parameter int SMP_BASE   = 4,
  parameter int BIT_BASE   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic [CH_W-1:0]  ch_i,
  input  logic [CT_W-1:0]  ctime_i,
  input  logic             cmp_i,
  output logic [CH_W-1:0]  ch_sel_o,
  output logic             sample_o,
  output logic [RES-1:0]   dac_code_o,
  output logic [RES_W-1:0] result_o,
  output logic [HI_W-1:0]  result_hi_o,
  output logic             eoc_o
);
  localparam int MAX_BASE = (SMP_BASE > BIT_BASE) ? SMP_BASE : BIT_BASE;
  localparam int MAX_LEN  = MAX_BASE * (1 << CT_W);
  localparam int PH_W     = $clog2(MAX_LEN + 1);
  localparam int PAD      = RES_W - RES;

  sar_state_e       st_q;
  logic [PH_W-1:0]  cnt_q, smp_len_in, bit_len_q;
  logic [CH_W-1:0]  ch_q;
  logic [CT_W-1:0]  ct_q;
  logic [RES_W-1:0] res_q;
  logic [HI_W-1:0]  hi_q;
  logic             eoc_q;
  logic             warm_w, abort_w, go_w, load_w, step_w, last_w;
  logic [RES-1:0]   trial_w, final_w;

  sar_warmup #(.SETTLE_CYC(SETTLE_CYC)) u_warm (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .warm_o(warm_w)
  );

  sar_reg #(.RES(RES)) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .step_i (step_w),
    .cmp_i  (cmp_i),
    .trial_o(trial_w),
    .final_o(final_w),
    .last_o (last_w)
  );

  assign smp_len_in = PH_W'(SMP_BASE) * (PH_W'(ctime_i) + PH_W'(1));
  assign bit_len_q  = PH_W'(BIT_BASE) * (PH_W'(ct_q) + PH_W'(1));

  assign abort_w = !run_i || !en_i;
  assign go_w    = run_i && en_i && warm_w;
  assign load_w  = (st_q == ST_SAMPLE) && (cnt_q == '0) && !abort_w;
  assign step_w  = (st_q == ST_CONV)   && (cnt_q == '0) && !abort_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ch_q  <= '0;
      ct_q  <= '0;
      res_q <= '0;
      hi_q  <= '0;
      eoc_q <= 1'b0;
    end else begin
      eoc_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (go_w) begin
          st_q  <= ST_SAMPLE;
          ch_q  <= ch_i;
          ct_q  <= ctime_i;
          cnt_q <= smp_len_in - PH_W'(1);
        end
        ST_SAMPLE: begin
          if (abort_w)              st_q <= ST_IDLE;
          else if (cnt_q == '0) begin
            st_q  <= ST_CONV;
            cnt_q <= bit_len_q - PH_W'(1);
          end else                  cnt_q <= cnt_q - PH_W'(1);
        end
        ST_CONV: begin
          if (abort_w)              st_q <= ST_IDLE;
          else if (cnt_q != '0)     cnt_q <= cnt_q - PH_W'(1);
          else if (!last_w)         cnt_q <= bit_len_q - PH_W'(1);
          else begin
            // done: latch and re-arm straight into sampling
            res_q <= {final_w, {PAD{1'b0}}};
            hi_q  <= final_w[RES-1 -: HI_W];
            eoc_q <= 1'b1;
            st_q  <= ST_SAMPLE;
            ch_q  <= ch_i;
            ct_q  <= ctime_i;
            cnt_q <= smp_len_in - PH_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_sel_o    = ch_q;
  assign sample_o    = (st_q == ST_SAMPLE);
  assign dac_code_o  = trial_w;
  assign result_o    = res_q;
  assign result_hi_o = hi_q;
  assign eoc_o       = eoc_q;

  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o) else $error("eoc longer than one cycle"); // R8
  AST_RESULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> $stable(result_o) && $stable(result_hi_o)) else $error("result moved without eoc"); // R10
  AST_HI_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> result_hi_o == result_o[RES_W-1 -: HI_W]) else $error("high byte mismatch"); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_w |=> !sample_o && !eoc_o) else $error("no abort"); // R10
  AST_NO_COLD_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) |-> $past(warm_w)) else $error("sampling before settle"); // R2
  AST_CH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CONV && $past(st_q) == ST_CONV) |-> $stable(ch_sel_o)) else $error("channel moved mid conversion"); // R11
endmodule

// File: tb/sar_adc_seq_test.sv
`timescale 1ns/1ps
module sar_adc_seq_test;
  localparam int SETTLE = 250;
  localparam int SMPB   = 4;
  localparam int BITB   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, run = 1'b0, cmp;
  logic [2:0]  ch = '0, ctime = '0;
  logic [9:0]  vin = '0;
  logic [2:0]  ch_sel;
  logic        sample, eoc;
  logic [9:0]  dac;
  logic [15:0] res;
  logic [7:0]  res_hi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign cmp = (vin >= dac);  // ideal comparator

  sar_adc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .run_i(run), .ch_i(ch),
    .ctime_i(ctime), .cmp_i(cmp), .ch_sel_o(ch_sel), .sample_o(sample),
    .dac_code_o(dac), .result_o(res), .result_hi_o(res_hi), .eoc_o(eoc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_eoc(input int lim, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!eoc && n < lim);
  endtask

  function automatic int conv_len(input int ct);
    return SMPB * (ct + 1) + 10 * BITB * (ct + 1);
  endfunction

  task automatic chk_result(input string req, input logic [9:0] code);
    chk({req, " result"}, res, {code, 6'b0});
    chk({req, " high byte"}, res_hi, code[9:2]);
  endtask

  task automatic t_reset;
    chk("R1 result", res, 0);
    chk("R1 high", res_hi, 0);
    chk("R1 dac", dac, 0);
    chk("R1 sample", sample, 0);
    chk("R1 eoc", eoc, 0);
  endtask

  task automatic t_settle_and_stream;
    int n, m;
    @(negedge clk);
    en = 1; run = 1; ch = 3'd2; ctime = 3'd0; vin = 10'h155;
    n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!sample && n < 1000);
    chk("R2 first sample edge", n, SETTLE + 1);
    chk("R11 channel captured", ch_sel, 2);
    m = 1;
    forever begin
      @(posedge clk); @(negedge clk);
      if (sample) m++; else break;
    end
    chk("R3 sample length", m, SMPB);
    chk("R4 first trial", dac, 10'h200);
    wait_eoc(1000, n);
    chk("R6 bit trials to eoc", n, 10 * BITB);
    chk_result("R5 R7", 10'h155);
    vin = 10'h2C3;
    @(posedge clk); @(negedge clk);
    chk("R8 eoc single cycle", eoc, 0);
    chk("R3 sample during restart", sample, 1);
    wait_eoc(1000, n);
    chk("R9 back-to-back period", n + 1, conv_len(0));
    chk_result("R9", 10'h2C3);
    run = 0;
    @(posedge clk); @(negedge clk);
    chk("R10 idle after stop", sample, 0);
  endtask

  task automatic t_slow;
    int n;
    @(negedge clk);
    ctime = 3'd7; vin = 10'h000; run = 1;
    wait_eoc(1000, n);
    chk("R6 R13 slow start to eoc", n, 1 + conv_len(7));
    chk_result("R13 zero", 10'h000);
    vin = 10'h3FF;
    wait_eoc(1000, n);
    chk("R13 slow period", n, conv_len(7));
    chk_result("R5 full scale", 10'h3FF);
    run = 0; ctime = 3'd0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_abort;
    int seen = 0;
    @(negedge clk);
    vin = 10'h0AA; run = 1;
    repeat (12) @(negedge clk);
    run = 0;
    repeat (40) begin
      @(posedge clk); @(negedge clk);
      if (eoc) seen++;
    end
    chk("R10 no eoc after abort", seen, 0);
    chk("R10 sample low", sample, 0);
    chk_result("R10 kept", 10'h3FF);
  endtask

  task automatic t_channel;
    int n = 0, bad = 0;
    @(negedge clk);
    ch = 3'd1; vin = 10'h100; run = 1;
    repeat (8) begin @(posedge clk); n++; @(negedge clk); end
    ch = 3'd5;
    while (!eoc && n < 1000) begin
      if (ch_sel != 3'd1) bad++;
      @(posedge clk); n++; @(negedge clk);
    end
    chk("R11 old channel held", bad, 0);
    chk("R11 new channel at restart", ch_sel, 5);
    chk_result("R5", 10'h100);
    run = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_enable_drop;
    int n;
    @(negedge clk);
    en = 0;
    repeat (3) @(negedge clk);
    en = 1; run = 1; ch = 3'd0; vin = 10'h07F;
    wait_eoc(2000, n);
    chk("R12 full settle again", n, SETTLE + 1 + conv_len(0));
    chk_result("R12", 10'h07F);
    run = 0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_settle_and_stream();
    t_slow();
    t_abort();
    t_channel();
    t_enable_drop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule